// File: doc/BRIEF.md
# Optical Track Crossing Counter

This block counts track crossings for a seek of an optical disc pickup under control of a host microcontroller. The host places a binary target on a parallel count bus and pulses a load strobe. The run begins when the strobe falls. While the run lasts, a tracking-off output stays high so that the tracking loop is opened. The crossing pulses from the pickup arrive asynchronously and are resynchronised before they are counted.

A shared monitor line reports progress. During a run it rises once half of the target has been crossed and falls when the whole target has been crossed. The count then starts over with the same target, and this repeats until the host issues a reset command. A long seek is therefore done by loading a moderate target and counting the falling edges of the monitor. When no run is active, the monitor line carries the normal subcode-ready flag instead.

Top module: `track_cross_counter`

## Requirements
- R1: On the clock edge where `cmdLatch` is seen going from 1 to 0 and `cmdCount` is nonzero, the value on `cmdCount` becomes the target, the crossing count clears and a run starts.
- R2: `trackOff` is 1 from the edge that starts a run until a reset command, and 0 otherwise.
- R3: At the start of every repetition `monitor` is 0. It becomes 1 when the count within the repetition reaches floor(target/2), provided that value is nonzero; for a target of 1 it stays 0.
- R4: On the crossing that makes the count equal to the target, `monitor` goes to 0 and counting restarts from zero with the same target.
- R5: A target of 200 driven with 20,000 crossings gives exactly 100 falling edges on `monitor`, and the run is still active afterwards.
- R6: A `resetCmd` high at a clock edge ends any run at that edge, clears the count and drives `trackOff` low. It takes priority over a strobe fall in the same cycle.
- R7: While no run is active, `monitor` equals `subcodeReady`.
- R8: A strobe fall with `cmdCount` equal to zero is ignored. An idle block stays idle, and an active run keeps its target and its count.
- R9: `trackPulse` passes through a two-flop synchronizer, and each rising edge counts as one crossing however long the pulse stays high. Crossings that arrive while no run is active are not counted.
- R10: A nonzero load during a run restarts the run with the new target from a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdCount | input | TRK_W | Binary target track count |
| cmdLatch | input | 1 | Load strobe; its falling edge starts a run |
| resetCmd | input | 1 | Reset command; ends counting |
| subcodeReady | input | 1 | Normal subcode-ready flag, routed to `monitor` when idle |
| trackPulse | input | 1 | Asynchronous track-crossing pulse |
| trackOff | output | 1 | High while a run is active |
| monitor | output | 1 | Run progress during a run, otherwise `subcodeReady` |

## Verification
The bench builds the block with an 8-bit count width. This lets it sweep every target from 1 to 12 over two full repetitions each, and check the monitor level after every single crossing against floor(N/2) and N computed in the bench. The 8-bit width still holds a target of 200, so the long seek of 20,000 crossings runs in full with the falling edges counted. The bench also covers the edge cases: a held-high pulse, crossings while idle, zero loads, a reload during a run, and a reset that coincides with a strobe fall.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic loadTarget;
    logic clearCount;
    logic incCount;
  } ttcStrobe_t;
endpackage

// File: rtl/ttc_datapath.sv
module ttc_datapath
  import ttc_pkg::*;
#(
  parameter int TRK_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trackPulse,
  input  logic [TRK_W-1:0] cmdCount,
  input  ttcStrobe_t       strobe,
  output logic             crossSeen,
  output logic             hitHalf,
  output logic             hitEnd,
  output logic             cmdNonZero
);
  localparam int SYNC_N = 3;  // two synchronizer stages plus one edge stage

  logic [SYNC_N-1:0] syncPipe;
  logic [TRK_W-1:0]  target;
  logic [TRK_W-1:0]  count;
  logic [TRK_W-1:0]  countNext;
  logic [TRK_W-1:0]  halfMark;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_N-2:0], trackPulse};
  end

  assign crossSeen = syncPipe[1] & ~syncPipe[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  target <= '0;
    else if (strobe.loadTarget) target <= cmdCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  count <= '0;
    else if (strobe.clearCount) count <= '0;
    else if (strobe.incCount)   count <= countNext;
  end

  assign countNext  = count + TRK_W'(1);
  assign halfMark   = target >> 1;
  assign hitHalf    = (halfMark != '0) && (countNext == halfMark);
  assign hitEnd     = (countNext == target);
  assign cmdNonZero = |cmdCount;
endmodule

// File: rtl/ttc_control.sv
module ttc_control
  import ttc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdLatch,
  input  logic       resetCmd,
  input  logic       crossSeen,
  input  logic       hitHalf,
  input  logic       hitEnd,
  input  logic       cmdNonZero,
  output ttcStrobe_t strobe,
  output logic       runActive,
  output logic       halfFlag
);
  logic latchPrev;
  logic latchFall;
  logic startRun;
  logic stepRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchPrev <= 1'b0;
    else       latchPrev <= cmdLatch;
  end

  assign latchFall = latchPrev & ~cmdLatch;
  assign startRun  = latchFall & cmdNonZero & ~resetCmd;
  assign stepRun   = runActive & crossSeen & ~resetCmd & ~startRun;

  always_comb begin
    strobe            = '0;
    strobe.loadTarget = startRun;
    strobe.clearCount = startRun | resetCmd | (stepRun & hitEnd);
    strobe.incCount   = stepRun & ~hitEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runActive <= 1'b0;
    else if (resetCmd) runActive <= 1'b0;
    else if (startRun) runActive <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    halfFlag <= 1'b0;
    else if (resetCmd | startRun) halfFlag <= 1'b0;
    else if (stepRun) begin
      if (hitEnd)       halfFlag <= 1'b0;
      else if (hitHalf) halfFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/track_cross_counter.sv
module track_cross_counter
  import ttc_pkg::*;
#(
  parameter int TRK_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TRK_W-1:0] cmdCount,
  input  logic             cmdLatch,
  input  logic             resetCmd,
  input  logic             subcodeReady,
  input  logic             trackPulse,
  output logic             trackOff,
  output logic             monitor
);
  ttcStrobe_t strobe;
  logic crossSeen, hitHalf, hitEnd, cmdNonZero;
  logic runActive, halfFlag;

  ttc_datapath #(.TRK_W(TRK_W)) datapath_i (
    .clk(clk), .rstN(rstN), .trackPulse(trackPulse), .cmdCount(cmdCount),
    .strobe(strobe), .crossSeen(crossSeen), .hitHalf(hitHalf),
    .hitEnd(hitEnd), .cmdNonZero(cmdNonZero)
  );

  ttc_control control_i (
    .clk(clk), .rstN(rstN), .cmdLatch(cmdLatch), .resetCmd(resetCmd),
    .crossSeen(crossSeen), .hitHalf(hitHalf), .hitEnd(hitEnd),
    .cmdNonZero(cmdNonZero), .strobe(strobe), .runActive(runActive),
    .halfFlag(halfFlag)
  );

  assign trackOff = runActive;
  assign monitor  = runActive ? halfFlag : subcodeReady;
endmodule

// File: rtl/track_cross_counter_chk.sv
module track_cross_counter_chk #(
  parameter int TRK_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [TRK_W-1:0] cmdCount,
  input logic             cmdLatch,
  input logic             resetCmd,
  input logic             trackOff,
  input logic             monitor
);
  p_start_on_fall_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cmdLatch) && cmdCount != '0 && !resetCmd) |=> trackOff);

  p_trackoff_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trackOff && !resetCmd) |=> trackOff);

  p_monitor_low_at_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trackOff) |-> !monitor);

  p_reset_stops_r6: assert property (@(posedge clk) disable iff (!rstN)
    resetCmd |=> !trackOff);

  p_zero_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!trackOff && $fell(cmdLatch) && cmdCount == '0) |=> !trackOff);
endmodule

bind track_cross_counter track_cross_counter_chk #(.TRK_W(TRK_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmdCount(cmdCount), .cmdLatch(cmdLatch),
  .resetCmd(resetCmd), .trackOff(trackOff), .monitor(monitor)
);

// File: tb/track_cross_counter_tb_top.sv
module track_cross_counter_tb_top;
  localparam int TRK_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [TRK_W-1:0] cmdCount = '0;
  logic cmdLatch = 1'b0;
  logic resetCmd = 1'b0;
  logic subcodeReady = 1'b0;
  logic trackPulse = 1'b0;
  logic trackOff;
  logic monitor;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  track_cross_counter #(.TRK_W(TRK_W)) dut_i (
    .clk(clk), .rstN(rstN), .cmdCount(cmdCount), .cmdLatch(cmdLatch),
    .resetCmd(resetCmd), .subcodeReady(subcodeReady), .trackPulse(trackPulse),
    .trackOff(trackOff), .monitor(monitor)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic loadTarget(input int n);
    @(negedge clk); cmdCount = TRK_W'(n); cmdLatch = 1'b1;
    @(negedge clk); cmdLatch = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendReset();
    @(negedge clk); resetCmd = 1'b1;
    @(negedge clk); resetCmd = 1'b0;
    @(negedge clk);
  endtask

  task automatic crossing(input int highCycles);
    trackPulse = 1'b1;
    repeat (highCycles) @(negedge clk);
    trackPulse = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic expMon(input int n, input int k);
    int h = n / 2;
    return (h > 0 && k >= h && k < n);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset trackOff", trackOff, 1'b0);
    check("R7 reset monitor", monitor, subcodeReady);

    // Sweep every small target over two repetitions
    for (int n = 1; n <= 12; n++) begin
      loadTarget(n);
      check("R1 run started", trackOff, 1'b1);
      check("R3 monitor low at start", monitor, 1'b0);
      for (int rep = 0; rep < 2; rep++) begin
        for (int k = 1; k <= n; k++) begin
          crossing(2);
          check((k == n) ? "R4 complete and restart" : "R3 half point",
                monitor, expMon(n, k));
          check("R2 trackOff held", trackOff, 1'b1);
        end
      end
      sendReset();
      check("R6 reset ends run", trackOff, 1'b0);
    end

    // R7 idle monitor mirrors subcode flag
    subcodeReady = 1'b1; @(negedge clk);
    check("R7 idle monitor high", monitor, 1'b1);
    subcodeReady = 1'b0; @(negedge clk);
    check("R7 idle monitor low", monitor, 1'b0);

    // R9 crossings while idle ignored
    subcodeReady = 1'b1;
    for (int i = 0; i < 5; i++) crossing(2);
    check("R9 idle crossings leave idle", trackOff, 1'b0);
    loadTarget(4);
    check("R7 monitor switches to progress", monitor, 1'b0);
    crossing(2);
    check("R9 idle crossings not counted", monitor, 1'b0);
    crossing(2);
    check("R3 half after idle crossings", monitor, 1'b1);
    sendReset();
    check("R7 monitor restored after reset", monitor, 1'b1);
    subcodeReady = 1'b0;

    // R9 held-high pulse counts once
    loadTarget(4);
    crossing(20);
    check("R9 long pulse counted once", monitor, 1'b0);
    crossing(2);
    check("R9 second crossing reaches half", monitor, 1'b1);
    sendReset();

    // R8 zero load while idle and while active
    loadTarget(0);
    check("R8 zero load idle", trackOff, 1'b0);
    loadTarget(6);
    crossing(2); crossing(2);
    loadTarget(0);
    check("R8 zero load keeps run", trackOff, 1'b1);
    crossing(2);
    check("R8 count kept across zero load", monitor, 1'b1);
    sendReset();

    // R10 reload during run
    loadTarget(8);
    crossing(2); crossing(2); crossing(2);
    loadTarget(4);
    check("R10 reload clears monitor", monitor, 1'b0);
    crossing(2);
    check("R10 new target count 1", monitor, 1'b0);
    crossing(2);
    check("R10 new target half", monitor, 1'b1);
    sendReset();

    // R6 reset wins over a simultaneous strobe fall
    @(negedge clk); cmdCount = 8'd5; cmdLatch = 1'b1;
    @(negedge clk); cmdLatch = 1'b0; resetCmd = 1'b1;
    @(negedge clk); resetCmd = 1'b0;
    @(negedge clk);
    check("R6 reset priority over load", trackOff, 1'b0);

    // R5 long seek: 200 x 100
    begin
      int falls = 0;
      logic prevMon;
      loadTarget(200);
      prevMon = monitor;
      for (int i = 0; i < 20000; i++) begin
        crossing(2);
        if (prevMon && !monitor) falls++;
        prevMon = monitor;
      end
      checks++;
      if (falls != 100) begin
        fails++;
        $display("FAIL R5 monitor falls: actual %0d expected 100", falls);
      end
      check("R5 run still active", trackOff, 1'b1);
      check("R5 monitor low after full cycle", monitor, 1'b0);
    end
    sendReset();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule